// File: doc/BRIEF.md
# Programmable Serial Bit-Rate Generator

This block turns a free-running reference clock into two strobes for a serial transceiver. A sample strobe fires once per oversampling slot. A bit strobe fires once per serial bit period. The rate is set by three writable settings:

- a clock-select flag, which inserts a fixed divide-by-8 ahead of everything else;
- a 16-bit slot divisor;
- an 8-bit slot count per bit, which holds the count minus one.

The resulting bit rate is the selected clock divided by (slot divisor × (slot count + 1)).

Settings are written through a simple strobe/address/data port. A write whose value is out of range for its field is dropped: it changes nothing and does not restart the counters. Every accepted write restarts the prescaler and both counters from zero, so the first period after the change is a full one.

The same mode write also carries the character-format fields. These are decoded once, at write time, into registered outputs for the neighbouring shifter.

Top module: `ubrg_top`

## Requirements
- R1: While `rst` is high and right after it, the slot divisor reads 0x28B, the slot count reads 0xF, the prescaler is off, the format outputs show 8 data bits, even parity (code 0) and two stop bits, and both strobes are low.
- R2: A write to address 1 with a value of at least 1 stores its low 16 bits. A write of 0 is dropped and does not restart the counters.
- R3: A write to address 2 with a value of at least 4 stores its low 8 bits. A value below 4 is dropped and does not restart the counters.
- R4: Bit 0 of a write to address 0 selects the divided clock. With it set, every period is P = 8 times longer than with it clear (P = 1).
- R5: With no writes, `sample_en` is a one-cycle pulse every P × D cycles, where D is the stored slot divisor and a stored value of 0 means 65536.
- R6: `bit_en` pulses only together with `sample_en`, once every N + 1 sample pulses, where N is the stored slot count and a stored 0 means every pulse.
- R7: After the clock edge that takes an accepted write, the first `sample_en` comes exactly P × D cycles later and the first `bit_en` exactly P × D × (N + 1) cycles later. Neither strobe pulses before then.
- R8: Mode bits 2:1 give the data length on `data_bits_o`: 3 gives 6, 2 gives 7, any other value gives 8.
- R9: Mode bits 5:3 give `parity_o`: 0 gives code 0 (even), 1 gives code 1 (odd), any other value gives code 2 (none).
- R10: Mode bits 7:6 equal to 3 give one stop bit (`two_stop_o` low). Any other value gives two stop bits.
- R11: A write to address 3 changes no setting and does not restart the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | 0 mode, 1 slot divisor, 2 slot count, 3 unused |
| cfg_wdata | input | 32 | Write value |
| sample_en | output | 1 | One-cycle oversampling strobe |
| bit_en | output | 1 | One-cycle bit-period strobe |
| clkdiv_o | output | 16 | Stored slot divisor |
| bitdiv_o | output | 8 | Stored slot count minus one |
| prediv_o | output | 1 | Divide-by-8 prescaler selected |
| data_bits_o | output | 4 | Decoded data length (6, 7 or 8) |
| parity_o | output | 2 | 0 even, 1 odd, 2 none |
| two_stop_o | output | 1 | High for two stop bits |

## Verification
The stored settings come out directly on ports. A wrong store or a dropped write that still landed therefore shows up one cycle after the write.

A counter left in a stale state after a write cannot be seen directly. It shows as a first strobe that arrives early or late relative to the write edge, so the bench times the first and second bit periods from each accepted write.

A slot counter that drifts out of step with the bit counter shows at the very next `bit_en`. At that point the number of sample pulses since the previous bit differs from N + 1.

// File: rtl/ubrg_pkg.sv
package ubrg_pkg;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_CLKDIV = 2'd1,
    SEL_BITDIV = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    PAR_EVEN = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_NONE = 2'd2
  } parity_e;

  localparam int CLKDIV_MIN = 1;
  localparam int BITDIV_MIN = 4;

endpackage

// File: rtl/ubrg_cfg.sv
module ubrg_cfg
  import ubrg_pkg::*;
#(
  parameter int WD_W   = 32,
  parameter int CD_W   = 16,
  parameter int BD_W   = 8,
  parameter int CD_RST = 'h28B,
  parameter int BD_RST = 'hF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [1:0]      addr,
  input  logic [WD_W-1:0] wdata,
  output logic            restart,
  output logic [CD_W-1:0] clkdiv_q,
  output logic [BD_W-1:0] bitdiv_q,
  output logic            prediv_q,
  output logic [3:0]      data_bits_q,
  output logic [1:0]      parity_q,
  output logic            two_stop_q
);

  logic wr_mode, wr_cd, wr_bd;

  always_comb begin
    wr_mode = we && (addr == SEL_MODE);
    wr_cd   = we && (addr == SEL_CLKDIV) && (wdata >= WD_W'(CLKDIV_MIN));
    wr_bd   = we && (addr == SEL_BITDIV) && (wdata >= WD_W'(BITDIV_MIN));
    restart = wr_mode || wr_cd || wr_bd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clkdiv_q    <= CD_W'(CD_RST);
      bitdiv_q    <= BD_W'(BD_RST);
      prediv_q    <= 1'b0;
      data_bits_q <= 4'd8;
      parity_q    <= PAR_EVEN;
      two_stop_q  <= 1'b1;
    end else begin
      if (wr_cd) clkdiv_q <= wdata[CD_W-1:0];
      if (wr_bd) bitdiv_q <= wdata[BD_W-1:0];
      if (wr_mode) begin
        prediv_q <= wdata[0];
        case (wdata[2:1])
          2'b11:   data_bits_q <= 4'd6;
          2'b10:   data_bits_q <= 4'd7;
          default: data_bits_q <= 4'd8;
        endcase
        case (wdata[5:3])
          3'd0:    parity_q <= PAR_EVEN;
          3'd1:    parity_q <= PAR_ODD;
          default: parity_q <= PAR_NONE;
        endcase
        two_stop_q <= (wdata[7:6] != 2'b11);
      end
    end
  end

endmodule

// File: rtl/ubrg_prescale.sv
module ubrg_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic enable,
  output logic tick
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] cnt;
  logic          wrap;

  always_comb begin
    wrap = (cnt == PW'(DIV - 1));
    tick = enable ? wrap : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (enable)    cnt <= wrap ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/ubrg_divcnt.sv
module ubrg_divcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic         fire
);

  logic [W-1:0] cnt;

  always_comb fire = step && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (step)      cnt <= fire ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/ubrg_top.sv
module ubrg_top #(
  parameter int WD_W     = 32,
  parameter int CD_W     = 16,
  parameter int BD_W     = 8,
  parameter int PRE_DIV  = 8,
  parameter int CD_RST   = 'h28B,
  parameter int BD_RST   = 'hF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [WD_W-1:0] cfg_wdata,
  output logic            sample_en,
  output logic            bit_en,
  output logic [CD_W-1:0] clkdiv_o,
  output logic [BD_W-1:0] bitdiv_o,
  output logic            prediv_o,
  output logic [3:0]      data_bits_o,
  output logic [1:0]      parity_o,
  output logic            two_stop_o
);

  logic            restart, ref_tick, slot_fire, bit_fire;
  logic [CD_W-1:0] slot_last;

  ubrg_cfg #(
    .WD_W(WD_W), .CD_W(CD_W), .BD_W(BD_W), .CD_RST(CD_RST), .BD_RST(BD_RST)
  ) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .restart(restart), .clkdiv_q(clkdiv_o), .bitdiv_q(bitdiv_o),
    .prediv_q(prediv_o), .data_bits_q(data_bits_o), .parity_q(parity_o),
    .two_stop_q(two_stop_o)
  );

  ubrg_prescale #(.DIV(PRE_DIV)) pre_i (
    .clk(clk), .rst(rst), .restart(restart), .enable(prediv_o), .tick(ref_tick)
  );

  // a stored divisor of 0 wraps to all ones: a full 2**CD_W count
  always_comb slot_last = clkdiv_o - {{(CD_W-1){1'b0}}, 1'b1};

  ubrg_divcnt #(.W(CD_W)) slot_i (
    .clk(clk), .rst(rst), .restart(restart), .step(ref_tick),
    .last(slot_last), .fire(slot_fire)
  );

  ubrg_divcnt #(.W(BD_W)) bit_i (
    .clk(clk), .rst(rst), .restart(restart), .step(slot_fire),
    .last(bitdiv_o), .fire(bit_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_en <= 1'b0;
      bit_en    <= 1'b0;
    end else begin
      sample_en <= slot_fire && !restart;
      bit_en    <= bit_fire && !restart;
    end
  end

endmodule

// File: rtl/ubrg_chk.sv
module ubrg_chk #(
  parameter int WD_W = 32,
  parameter int CD_W = 16,
  parameter int BD_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic [1:0]      cfg_addr,
  input logic [WD_W-1:0] cfg_wdata,
  input logic            sample_en,
  input logic            bit_en,
  input logic [CD_W-1:0] clkdiv_o,
  input logic [BD_W-1:0] bitdiv_o,
  input logic            prediv_o,
  input logic [3:0]      data_bits_o,
  input logic [1:0]      parity_o,
  input logic            two_stop_o
);

  logic          accepted;
  logic [BD_W:0] since_bit;

  always_comb accepted = cfg_we && ((cfg_addr == 2'd0) ||
                         (cfg_addr == 2'd1 && cfg_wdata != '0) ||
                         (cfg_addr == 2'd2 && cfg_wdata >= WD_W'(4)));

  always_ff @(posedge clk) begin
    if (rst || accepted) since_bit <= '0;
    else if (sample_en)  since_bit <= bit_en ? '0 : since_bit + 1'b1;
  end

  assert_cd_store_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 2'd1 && cfg_wdata != '0) |=> (clkdiv_o == $past(cfg_wdata[CD_W-1:0])));

  assert_cd_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 2'd1 && cfg_wdata == '0) |=> $stable(clkdiv_o));

  assert_bd_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 2'd2 && cfg_wdata < WD_W'(4)) |=> $stable(bitdiv_o));

  assert_bit_in_slot_R6: assert property (@(posedge clk) disable iff (rst)
    bit_en |-> sample_en);

  assert_bit_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    bit_en |-> (since_bit == {1'b0, bitdiv_o}));

  assert_quiet_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    accepted |=> (!sample_en && !bit_en));

  assert_unused_addr_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 2'd3) |=> ($stable(clkdiv_o) && $stable(bitdiv_o) && $stable(prediv_o)));

endmodule

bind ubrg_top ubrg_chk #(.WD_W(WD_W), .CD_W(CD_W), .BD_W(BD_W)) chk_i (.*);

// File: tb/ubrg_top_tb_top.sv
module ubrg_top_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        sample_en, bit_en, prediv_o, two_stop_o;
  logic [15:0] clkdiv_o;
  logic [7:0]  bitdiv_o;
  logic [3:0]  data_bits_o;
  logic [1:0]  parity_o;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ubrg_top dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sample_en(sample_en), .bit_en(bit_en), .clkdiv_o(clkdiv_o), .bitdiv_o(bitdiv_o),
    .prediv_o(prediv_o), .data_bits_o(data_bits_o), .parity_o(parity_o),
    .two_stop_o(two_stop_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  // cycles from the last edge to the first sample and bit strobe, then one more bit period
  task automatic measure(input int exp_s, input int exp_b);
    int fs = 0, fb = 0, n = 0, orphan = 0, m = 0, ns = 0;
    while ((fs == 0 || (exp_b != 0 && fb == 0)) && n < 300000) begin
      @(posedge clk); #1; n++;
      if (bit_en && !sample_en) orphan++;
      if (sample_en && fs == 0) fs = n;
      if (bit_en && fb == 0) fb = n;
    end
    check(fs == exp_s, "R5 R7 first sample", fs, exp_s);
    if (exp_b != 0) begin
      check(fb == exp_b, "R6 R7 first bit", fb, exp_b);
      while (m < 300000) begin
        @(posedge clk); #1; m++;
        if (bit_en && !sample_en) orphan++;
        if (sample_en) ns++;
        if (bit_en) break;
      end
      check(m == exp_b, "R6 bit period", m, exp_b);
      check(ns == exp_b / exp_s, "R6 samples per bit", ns, exp_b / exp_s);
    end
    check(orphan == 0, "R6 bit without sample", orphan, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL R7 watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(clkdiv_o == 16'h28B, "R1 clkdiv", int'(clkdiv_o), 'h28B);
    check(bitdiv_o == 8'hF, "R1 bitdiv", int'(bitdiv_o), 'hF);
    check(!prediv_o, "R1 prediv", int'(prediv_o), 0);
    check(data_bits_o == 4'd8 && parity_o == 2'd0 && two_stop_o, "R1 format",
          int'({data_bits_o, parity_o, two_stop_o}), int'({4'd8, 2'd0, 1'b1}));
    check(!sample_en && !bit_en, "R1 strobes", int'({sample_en, bit_en}), 0);
    @(negedge clk);
    rst = 1'b0;
    measure(651, 651 * 16);

    // R4 R5 R6 R7 sweep
    for (int p = 0; p < 2; p++) begin
      for (int ci = 0; ci < 4; ci++) begin
        for (int bi = 0; bi < 2; bi++) begin
          int cd, bd, pm;
          cd = (ci == 0) ? 1 : (ci == 1) ? 2 : (ci == 2) ? 3 : 5;
          bd = (bi == 0) ? 4 : 6;
          pm = (p == 1) ? 8 : 1;
          wr(2'd0, 32'(p));
          wr(2'd1, 32'(cd));
          wr(2'd2, 32'(bd));
          check(prediv_o == p[0], "R4 prediv", int'(prediv_o), p);
          measure(pm * cd, pm * cd * (bd + 1));
        end
      end
    end

    // R2 R3 dropped and truncated writes
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd3);
    wr(2'd2, 32'd4);
    measure(3, 15);
    wr(2'd1, 32'd0);
    check(clkdiv_o == 16'd3, "R2 zero dropped", int'(clkdiv_o), 3);
    wr(2'd2, 32'd3);
    check(bitdiv_o == 8'd4, "R3 below four dropped", int'(bitdiv_o), 4);
    wr(2'd2, 32'h104);
    check(bitdiv_o == 8'd4, "R3 low byte kept", int'(bitdiv_o), 4);
    wr(2'd1, 32'h10002);
    check(clkdiv_o == 16'd2, "R2 low half kept", int'(clkdiv_o), 2);
    measure(2, 10);
    wr(2'd3, 32'hFFFF_FFFF);
    check(clkdiv_o == 16'd2 && bitdiv_o == 8'd4 && !prediv_o, "R11 unused address",
          int'({clkdiv_o, bitdiv_o}), int'({16'd2, 8'd4}));
    wr(2'd2, 32'h100);
    check(bitdiv_o == 8'd0, "R6 zero count stored", int'(bitdiv_o), 0);
    measure(2, 2);

    // R5 a stored zero divisor is a full 65536 count
    wr(2'd1, 32'h10000);
    check(clkdiv_o == 16'd0, "R2 wrapped divisor", int'(clkdiv_o), 0);
    measure(65536, 0);

    // R8 R9 R10 format decode over every mode value
    for (int v = 0; v < 256; v++) begin
      int eb, ep, es;
      eb = (((v >> 1) & 3) == 3) ? 6 : (((v >> 1) & 3) == 2) ? 7 : 8;
      ep = (((v >> 3) & 7) == 0) ? 0 : (((v >> 3) & 7) == 1) ? 1 : 2;
      es = (((v >> 6) & 3) == 3) ? 0 : 1;
      wr(2'd0, 32'(v));
      check(int'(data_bits_o) == eb, "R8 data length", int'(data_bits_o), eb);
      check(int'(parity_o) == ep, "R9 parity", int'(parity_o), ep);
      check(int'(two_stop_o) == es, "R10 stop bits", int'(two_stop_o), es);
      check(int'(prediv_o) == (v & 1), "R4 select bit", int'(prediv_o), v & 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule